// File: doc/BRIEF.md
# Extended Capability List Walker

This block keeps a 4 KB configuration space as 1024 dword words. It maintains a singly linked chain of extended capability headers in that space. The chain always begins at byte offset 0x100. Each header dword holds a 16-bit capability ID in bits [15:0], a 4-bit version in bits [19:16] and the byte offset of the next header in bits [31:20]. A next value of zero ends the chain.

The command port takes two operations:

- **Find** takes a 17-bit ID and follows the chain one header per cycle. It reports whether a header with that ID exists, where that header is, and which header came before it. An ID with bit 16 set can never match, so a find with such an ID reports the tail of the chain.
- **Append** uses that same tail search. It rewrites only the tail's next field so that it points at a new header, and then writes the new header with a zero next field.

A separate host port reads and writes the dword array directly. It is used to set up the memory and to inspect it while no command is running.

Top module: `ecap_walker`

## Requirements
- R1: After reset, `cmd_ack`, `cmd_err` and `cmd_found` are 0, and `hit_off` and `prev_off` are 0.
- R2: A find reports not found with `hit_off` = 0 and `prev_off` = 0, without error, when the dword at byte offset 0x100 is zero (empty list).
- R3: Header layout is ID [15:0], version [19:16], next offset [31:20]. A find reports `cmd_found` = 1 for the first header in chain order whose ID equals `cmd_id`. `hit_off` is that header's offset, and `prev_off` is the offset of the header visited just before it, or 0 when the match is the head.
- R4: A find that reaches a header with next = 0 without a match reports `cmd_found` = 0, `hit_off` = 0 and `prev_off` = the tail header's offset.
- R5: A find whose `cmd_id` has bit 16 set matches no header and so reports the tail offset as `prev_off`.
- R6: Following a nonzero next pointer below 0x100, above 0xFF8, or with bits [1:0] nonzero ends the operation with `cmd_err` = 1, `cmd_found` = 0 and both offsets 0.
- R7: A walk that would visit more than MAX_HOPS headers (default 1024), such as a cyclic chain, ends with `cmd_err` = 1.
- R8: An append at offset 0x100 writes the head dword as {next 0, `cmd_ver`, `cmd_id`[15:0]} and performs no walk.
- R9: An append at any other offset first rewrites the tail's bits [31:20] to `cmd_off`, keeping the tail's bits [19:0]. It then writes {0, `cmd_ver`, `cmd_id`[15:0]} at `cmd_off` and reports the tail as `prev_off`.
- R10: An append with `cmd_off` < 0x100, `cmd_off`[1:0] nonzero, `cmd_size` < 8 or `cmd_off` + `cmd_size` > 0x1000 reports `cmd_err` = 1 and leaves memory unchanged. An append at a non-head offset onto an empty list does the same.
- R11: `cmd_op` is 0 for find and 1 for append. Each accepted command produces exactly one single-cycle `cmd_ack`, and the results are held until the next acknowledge. `cmd_valid` is ignored while a command is in progress.
- R12: While idle, a host write stores `host_wdata` at dword index `host_widx`. `host_rdata` shows the dword at `host_widx` one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_op | input | 1 | 0 = find, 1 = append |
| cmd_id | input | 17 | Capability ID; bit 16 set means an ID that cannot exist |
| cmd_ver | input | 4 | Version for append |
| cmd_off | input | 12 | Byte offset of the header to append |
| cmd_size | input | 13 | Byte size of the appended capability |
| cmd_ack | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Operation ended in error |
| cmd_found | output | 1 | Find matched a header |
| hit_off | output | 12 | Offset of the matching header, else 0 |
| prev_off | output | 12 | Offset of the header before the match, or of the tail |
| host_we | input | 1 | Host write enable |
| host_widx | input | 10 | Host dword index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |

## Verification
The hardest conditions to reach are a chain the append path can never build: a cycle, or a next pointer that is out of range or misaligned. The bench writes such headers straight into memory through the host port and then issues finds over them. For the cyclic case it also pulses a second command partway through the thousand-cycle walk, to show that the request is ignored. Legality of append arguments is swept over offsets and sizes on both sides of each limit. Before each point the list is rebuilt to a single head.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int OFF_W = 12;                       // byte offset width (4 KB)
  localparam int IDX_W = OFF_W - 2;                // dword index width
  localparam int SIZE_W = OFF_W + 1;
  localparam logic [OFF_W-1:0] HEAD_OFF = 12'h100;
  localparam logic [OFF_W-1:0] LAST_OFF = 12'hFF8;
  localparam logic [SIZE_W:0] SPACE_END = 14'h1000;
  localparam logic [SIZE_W-1:0] MIN_SIZE = 13'd8;
  localparam logic OP_FIND = 1'b0;
  localparam logic OP_APPEND = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_HDR  = 2'd2
  } ecap_state_e;
endpackage

// File: rtl/ecap_cfg_mem.sv
module ecap_cfg_mem #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      store[idx] <= wdata;
    end
    rdata <= store[idx];
  end
endmodule

// File: rtl/ecap_hdr_eval.sv
module ecap_hdr_eval
  import ecap_pkg::*;
(
  input  logic [15:0]      hdr_id,
  input  logic [OFF_W-1:0] hdr_nxt,
  input  logic [16:0]      want_id,
  input  logic             match_en,
  output logic             is_hit,
  output logic             is_tail,
  output logic             nxt_bad
);
  always_comb begin
    is_hit  = match_en && !want_id[16] && (hdr_id == want_id[15:0]);
    is_tail = (hdr_nxt == '0);
    nxt_bad = !is_tail &&
              ((hdr_nxt < HEAD_OFF) || (hdr_nxt > LAST_OFF) || (hdr_nxt[1:0] != 2'b00));
  end
endmodule

// File: rtl/ecap_arg_check.sv
module ecap_arg_check
  import ecap_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic              bad,
  output logic              at_head
);
  logic [SIZE_W:0] span_end;

  always_comb begin
    span_end = {2'b00, off} + {1'b0, size};
    bad = (off < HEAD_OFF) || (off[1:0] != 2'b00) ||
          (size < MIN_SIZE) || (span_end > SPACE_END);
    at_head = (off == HEAD_OFF);
  end
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int MAX_HOPS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [16:0]       cmd_id,
  input  logic [3:0]        cmd_ver,
  input  logic [OFF_W-1:0]  cmd_off,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              cmd_ack,
  output logic              cmd_err,
  output logic              cmd_found,
  output logic [OFF_W-1:0]  hit_off,
  output logic [OFF_W-1:0]  prev_off,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_widx,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata
);
  localparam int HOP_W = (MAX_HOPS > 2) ? $clog2(MAX_HOPS) : 1;
  localparam logic [HOP_W-1:0] HOP_LAST = HOP_W'(MAX_HOPS - 1);
  localparam logic [IDX_W-1:0] HEAD_IDX = HEAD_OFF[OFF_W-1:2];

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe[1];

  // state
  ecap_state_e      state_q, state_n;
  logic             op_q, op_n;
  logic [16:0]      id_q, id_n;
  logic [3:0]       ver_q, ver_n;
  logic [OFF_W-1:0] off_q, off_n;
  logic [OFF_W-1:0] cur_q, cur_n;
  logic [OFF_W-1:0] prv_q, prv_n;
  logic [HOP_W-1:0] hop_q, hop_n;

  logic             ack_q, err_q, found_q;
  logic [OFF_W-1:0] hit_q, prev_q;
  logic             res_en, err_n, found_n;
  logic [OFF_W-1:0] hit_n, prev_n;

  // memory port
  logic             eng_we;
  logic [IDX_W-1:0] eng_idx;
  logic [31:0]      eng_wdata;
  logic             mem_we;
  logic [IDX_W-1:0] mem_idx;
  logic [31:0]      mem_wdata;
  logic [31:0]      mem_q;

  logic start, busy, eng_own;
  logic arg_bad, arg_head;
  logic ev_hit, ev_tail, ev_bad;
  logic list_empty;

  assign busy    = (state_q != ST_IDLE);
  assign start   = !busy && cmd_valid;
  assign eng_own = busy || start;

  always_comb begin
    mem_we    = eng_own ? eng_we    : host_we;
    mem_idx   = eng_own ? eng_idx   : host_widx;
    mem_wdata = eng_own ? eng_wdata : host_wdata;
  end

  ecap_cfg_mem #(.AW(IDX_W), .DW(32)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .idx   (mem_idx),
    .wdata (mem_wdata),
    .rdata (mem_q)
  );

  ecap_hdr_eval u_eval (
    .hdr_id   (mem_q[15:0]),
    .hdr_nxt  (mem_q[31:20]),
    .want_id  (id_q),
    .match_en (op_q == OP_FIND),
    .is_hit   (ev_hit),
    .is_tail  (ev_tail),
    .nxt_bad  (ev_bad)
  );

  ecap_arg_check u_args (
    .off     (cmd_off),
    .size    (cmd_size),
    .bad     (arg_bad),
    .at_head (arg_head)
  );

  assign list_empty = (hop_q == '0) && (mem_q == '0);

  // next state
  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    id_n    = id_q;
    ver_n   = ver_q;
    off_n   = off_q;
    cur_n   = cur_q;
    prv_n   = prv_q;
    hop_n   = hop_q;
    res_en  = 1'b0;
    err_n   = 1'b0;
    found_n = 1'b0;
    hit_n   = '0;
    prev_n  = '0;
    eng_we    = 1'b0;
    eng_idx   = cur_q[OFF_W-1:2];
    eng_wdata = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          op_n    = cmd_op;
          id_n    = (cmd_op == OP_FIND) ? cmd_id : {1'b0, cmd_id[15:0]};
          ver_n   = cmd_ver;
          off_n   = cmd_off;
          cur_n   = HEAD_OFF;
          prv_n   = '0;
          hop_n   = '0;
          eng_idx = HEAD_IDX;
          if ((cmd_op == OP_APPEND) && arg_bad) begin
            res_en = 1'b1;
            err_n  = 1'b1;
          end else if ((cmd_op == OP_APPEND) && arg_head) begin
            state_n = ST_HDR;
          end else begin
            state_n = ST_WALK;
          end
        end
      end

      ST_WALK: begin
        if (list_empty) begin
          res_en  = 1'b1;
          err_n   = (op_q == OP_APPEND);
          state_n = ST_IDLE;
        end else if (ev_hit) begin
          res_en  = 1'b1;
          found_n = 1'b1;
          hit_n   = cur_q;
          prev_n  = prv_q;
          state_n = ST_IDLE;
        end else if (ev_tail) begin
          if (op_q == OP_FIND) begin
            res_en  = 1'b1;
            prev_n  = cur_q;
            state_n = ST_IDLE;
          end else begin
            eng_we    = 1'b1;
            eng_idx   = cur_q[OFF_W-1:2];
            eng_wdata = {off_q, mem_q[19:0]};
            prv_n     = cur_q;
            state_n   = ST_HDR;
          end
        end else if (ev_bad || (hop_q == HOP_LAST)) begin
          res_en  = 1'b1;
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end else begin
          prv_n   = cur_q;
          cur_n   = mem_q[31:20];
          hop_n   = hop_q + 1'b1;
          eng_idx = mem_q[31:22];
        end
      end

      ST_HDR: begin
        eng_we    = 1'b1;
        eng_idx   = off_q[OFF_W-1:2];
        eng_wdata = {{OFF_W{1'b0}}, ver_q, id_q[15:0]};
        res_en    = 1'b1;
        prev_n    = prv_q;
        state_n   = ST_IDLE;
      end

      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_FIND;
      id_q    <= '0;
      ver_q   <= '0;
      off_q   <= '0;
      cur_q   <= '0;
      prv_q   <= '0;
      hop_q   <= '0;
    end else begin
      state_q <= state_n;
      if (start) begin
        op_q  <= op_n;
        id_q  <= id_n;
        ver_q <= ver_n;
        off_q <= off_n;
      end
      cur_q <= cur_n;
      prv_q <= prv_n;
      hop_q <= hop_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      found_q <= 1'b0;
      hit_q   <= '0;
      prev_q  <= '0;
    end else begin
      ack_q <= res_en;
      if (res_en) begin
        err_q   <= err_n;
        found_q <= found_n;
        hit_q   <= hit_n;
        prev_q  <= prev_n;
      end
    end
  end

  assign cmd_ack    = ack_q;
  assign cmd_err    = err_q;
  assign cmd_found  = found_q;
  assign hit_off    = hit_q;
  assign prev_off   = prev_q;
  assign host_rdata = mem_q;
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk
  import ecap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             op_q,
  input logic             eng_we,
  input logic             in_hdr,
  input logic             cmd_ack,
  input logic             cmd_err,
  input logic             cmd_found,
  input logic [OFF_W-1:0] hit_off,
  input logic [OFF_W-1:0] prev_off
);
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack);

  a_r11_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $past(start || busy));

  a_r3_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && cmd_found) |->
      (hit_off >= HEAD_OFF && hit_off <= LAST_OFF && hit_off[1:0] == 2'b00));

  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && !cmd_found) |-> (hit_off == '0));

  a_r6_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && cmd_err) |-> (!cmd_found && prev_off == '0));

  a_r10_find_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_FIND) |-> !eng_we);

  a_r9_hdr_completes: assert property (@(posedge clk) disable iff (!rst_n)
    in_hdr |=> (cmd_ack && !cmd_err));
endmodule

bind ecap_walker ecap_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .start     (start),
  .busy      (busy),
  .op_q      (op_q),
  .eng_we    (eng_we),
  .in_hdr    (state_q == ST_HDR),
  .cmd_ack   (cmd_ack),
  .cmd_err   (cmd_err),
  .cmd_found (cmd_found),
  .hit_off   (hit_off),
  .prev_off  (prev_off)
);

// File: tb/sim_ecap_walker.sv
`timescale 1ns/1ps
module sim_ecap_walker;
  logic        clk, rst_n;
  logic        cmd_valid, cmd_op;
  logic [16:0] cmd_id;
  logic [3:0]  cmd_ver;
  logic [11:0] cmd_off;
  logic [12:0] cmd_size;
  logic        cmd_ack, cmd_err, cmd_found;
  logic [11:0] hit_off, prev_off;
  logic        host_we;
  logic [9:0]  host_widx;
  logic [31:0] host_wdata, host_rdata;

  int n_chk = 0;
  int n_fail = 0;

  logic        r_err, r_found;
  logic [11:0] r_hit, r_prev;
  logic [31:0] rd;

  ecap_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_ver(cmd_ver),
    .cmd_off(cmd_off), .cmd_size(cmd_size),
    .cmd_ack(cmd_ack), .cmd_err(cmd_err), .cmd_found(cmd_found),
    .hit_off(hit_off), .prev_off(prev_off),
    .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [9:0] idx, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_widx = idx; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [9:0] idx, output logic [31:0] d);
    @(negedge clk);
    host_we = 1'b0; host_widx = idx;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic run_cmd(input logic op, input logic [16:0] id, input logic [3:0] ver,
                         input logic [11:0] off, input logic [12:0] size);
    int waited;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_ver = ver;
    cmd_off = off; cmd_size = size;
    waited = 0;
    forever begin
      @(negedge clk);
      cmd_valid = 1'b0;
      waited++;
      if (cmd_ack || waited > 4000) break;
    end
    chk("R11", "ack seen", {31'b0, cmd_ack}, 32'd1);
    r_err = cmd_err; r_found = cmd_found; r_hit = hit_off; r_prev = prev_off;
    @(negedge clk);
    chk("R11", "ack one cycle", {31'b0, cmd_ack}, 32'd0);
    chk("R11", "results held", {19'b0, cmd_found, hit_off}, {19'b0, r_found, r_hit});
  endtask

  function automatic logic [31:0] hdr(input logic [11:0] nxt, input logic [3:0] v,
                                      input logic [15:0] id);
    return {nxt, v, id};
  endfunction

  logic [11:0] n_off [4];
  logic [15:0] n_id  [4];
  logic [3:0]  n_ver [4];

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_id = '0; cmd_ver = '0;
    cmd_off = '0; cmd_size = '0; host_we = 1'b0; host_widx = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "ack", {31'b0, cmd_ack}, 32'd0);
    chk("R1", "err", {31'b0, cmd_err}, 32'd0);
    chk("R1", "found", {31'b0, cmd_found}, 32'd0);
    chk("R1", "hit", {20'b0, hit_off}, 32'd0);
    chk("R1", "prev", {20'b0, prev_off}, 32'd0);

    // R12 host port
    host_wr(10'h200, 32'hA5A5_0001);
    host_rd(10'h200, rd);
    chk("R12", "host readback", rd, 32'hA5A5_0001);

    // R2 empty list
    host_wr(10'h040, 32'h0);
    run_cmd(1'b0, 17'h00005, 4'h0, 12'h0, 13'h0);
    chk("R2", "empty err/found", {30'b0, r_err, r_found}, 32'd0);
    chk("R2", "empty offsets", {8'b0, r_hit, r_prev}, 32'd0);

    // R10 append to empty list at non-head offset
    host_wr(10'h080, 32'hDEAD_BEEF);
    run_cmd(1'b1, 17'h00042, 4'h1, 12'h200, 13'd8);
    chk("R10", "empty-list append err", {31'b0, r_err}, 32'd1);
    host_rd(10'h080, rd);
    chk("R10", "empty-list target untouched", rd, 32'hDEAD_BEEF);

    // R8/R9 build a chain by appends
    n_off = '{12'h100, 12'h140, 12'h2A0, 12'hFF8};
    n_id  = '{16'h0003, 16'h0010, 16'hBEEF, 16'h0010};
    n_ver = '{4'h1, 4'h2, 4'h3, 4'hF};
    for (int i = 0; i < 4; i++) begin
      run_cmd(1'b1, {1'b0, n_id[i]}, n_ver[i], n_off[i], 13'd8);
      chk(i == 0 ? "R8" : "R9", "append err", {31'b0, r_err}, 32'd0);
      chk(i == 0 ? "R8" : "R9", "append prev", {20'b0, r_prev},
          i == 0 ? 32'd0 : {20'b0, n_off[i-1]});
    end
    for (int i = 0; i < 4; i++) begin
      host_rd(n_off[i][11:2], rd);
      chk(i == 0 ? "R8" : "R9", "header image", rd,
          hdr(i == 3 ? 12'h0 : n_off[i+1], n_ver[i], n_id[i]));
    end

    // R3 find every present ID; first match wins
    for (int i = 0; i < 4; i++) begin
      int first;
      first = -1;
      for (int j = 3; j >= 0; j--) if (n_id[j] == n_id[i]) first = j;
      run_cmd(1'b0, {1'b0, n_id[i]}, 4'h0, 12'h0, 13'h0);
      chk("R3", "found", {30'b0, r_err, r_found}, 32'd1);
      chk("R3", "hit", {20'b0, r_hit}, {20'b0, n_off[first]});
      chk("R3", "prev", {20'b0, r_prev}, first == 0 ? 32'd0 : {20'b0, n_off[first-1]});
    end

    // R4 absent IDs report the tail
    for (int k = 0; k < 4; k++) begin
      logic [15:0] absent;
      absent = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0001 : (k == 2) ? 16'hFFFF : 16'h1234;
      run_cmd(1'b0, {1'b0, absent}, 4'h0, 12'h0, 13'h0);
      chk("R4", "miss flags", {30'b0, r_err, r_found}, 32'd0);
      chk("R4", "miss offsets", {8'b0, r_hit, r_prev}, {20'b0, 12'hFF8});
    end

    // R5 out-of-range ID, low bits equal a present ID
    run_cmd(1'b0, 17'h10003, 4'h0, 12'h0, 13'h0);
    chk("R5", "no match", {30'b0, r_err, r_found}, 32'd0);
    chk("R5", "tail as prev", {20'b0, r_prev}, {20'b0, 12'hFF8});

    // R6 bad next pointers
    for (int k = 0; k < 4; k++) begin
      logic [11:0] badp;
      badp = (k == 0) ? 12'h050 : (k == 1) ? 12'h142 : (k == 2) ? 12'hFFC : 12'h0FC;
      host_wr(10'h040, hdr(12'h140, 4'h1, 16'h0007));
      host_wr(10'h050, hdr(badp, 4'h1, 16'h0008));
      run_cmd(1'b0, 17'h00009, 4'h0, 12'h0, 13'h0);
      chk("R6", "bad pointer err", {30'b0, r_err, r_found}, 32'd2);
      chk("R6", "bad pointer offsets", {8'b0, r_hit, r_prev}, 32'd0);
    end

    // R7 cyclic chain, with a second request during the walk (R11)
    host_wr(10'h040, hdr(12'h100, 4'h1, 16'h0007));
    host_wr(10'h080, 32'hDEAD_BEEF);
    begin
      int acks;
      acks = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 1'b0; cmd_id = 17'h00009;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 1'b1; cmd_id = 17'h00042; cmd_off = 12'h200; cmd_size = 13'd8;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int c = 0; c < 1200; c++) begin
        @(negedge clk);
        if (cmd_ack) begin
          acks++;
          r_err = cmd_err;
        end
      end
      chk("R7", "cycle aborts with err", {31'b0, r_err}, 32'd1);
      chk("R11", "busy request ignored", acks, 32'd1);
    end
    host_rd(10'h040, rd);
    chk("R11", "head untouched", rd, hdr(12'h100, 4'h1, 16'h0007));
    host_rd(10'h080, rd);
    chk("R11", "target untouched", rd, 32'hDEAD_BEEF);

    // R10 append argument sweep, chain reset to one head each time
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 5; b++) begin
        logic [11:0] off;
        logic [12:0] sz;
        logic        bad;
        off = (a == 0) ? 12'h0F8 : (a == 1) ? 12'h0FC : (a == 2) ? 12'h100 :
              (a == 3) ? 12'h102 : (a == 4) ? 12'h180 : (a == 5) ? 12'hFF0 :
              (a == 6) ? 12'hFF8 : 12'hFFC;
        sz  = (b == 0) ? 13'd4 : (b == 1) ? 13'd7 : (b == 2) ? 13'd8 :
              (b == 3) ? 13'd12 : 13'd16;
        bad = (off < 12'h100) || (off[1:0] != 2'b00) || (sz < 13'd8) ||
              ({2'b0, off} + {1'b0, sz} > 14'h1000);
        if (off[11:2] != 10'h040) host_wr(off[11:2], 32'hDEAD_BEEF);
        host_wr(10'h040, hdr(12'h000, 4'h1, 16'h0007));
        run_cmd(1'b1, 17'h00042, 4'h5, off, sz);
        chk("R10", "append err flag", {31'b0, r_err}, {31'b0, bad});
        host_rd(10'h040, rd);
        if (bad)
          chk("R10", "head unchanged", rd, hdr(12'h000, 4'h1, 16'h0007));
        else if (off == 12'h100)
          chk("R8", "head rewritten", rd, hdr(12'h000, 4'h5, 16'h0042));
        else
          chk("R9", "tail next patched", rd, hdr(off, 4'h1, 16'h0007));
        if (off[11:2] != 10'h040) begin
          host_rd(off[11:2], rd);
          chk(bad ? "R10" : "R9", "target dword", rd,
              bad ? 32'hDEAD_BEEF : hdr(12'h000, 4'h5, 16'h0042));
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule